// File: doc/BRIEF.md
# Remapping Unit Global Command Handler

This block holds the global command word of an address/interrupt remapping unit and keeps a status word in step with it. Software writes a command word. The block compares the new word with the stored one, and only bits that differ enable or disable a feature. The features are:

- queued invalidation
- interrupt remapping
- bypass of compatibility-format interrupts

Two further command bits are one-shot triggers. Each copies a software-staged table address into an active pointer register and raises a sticky pointer-ready status bit.

Two parameters stand for the capability word. When a feature's capability is zero, its commands are not honoured. The root pointer trigger is never gated. The block gives downstream logic the status bits, the active pointers and the invalidation queue head. It also gives a one-cycle wake pulse for the queue engine. The queue engine updates the head through a dedicated strobe.

Top module: `gcmd_handler`

## Requirements
- R1: After reset, the stored command, the status word, both staging and active pointers, the queue head and the wake pulse are all zero.
- R2: When CAP_QI=1, a command write that changes bit 0 from 0 to 1 sets status bit 0. It also drives `qi_wake_o` high for exactly the cycle after the write. Rewriting bit 0 as 1 gives no pulse.
- R3: When CAP_QI=1, a command write that changes bit 0 from 1 to 0 clears status bit 0 and forces the queue head to zero. A write with bit 0 at 0 while it is already 0 leaves the head unchanged.
- R4: When CAP_IR=1, a change of command bit 1 sets status bit 1 to the new value.
- R5: When CAP_IR=1, a change of command bit 2 sets status bit 2 to the new value, where 1 means bypass and 0 means block.
- R6: When CAP_IR=1, a command write with bit 3 at 1 copies the interrupt table staging register (address 3) into the active interrupt table pointer and sets status bit 3.
- R7: A command write with bit 4 at 1 copies the root staging register (address 2) into the active root pointer and sets status bit 4, whatever CAP_IR is.
- R8: With CAP_QI=0, command bit 0 has no effect on status, wake or head. With CAP_IR=0, command bits 1 to 3 have no effect on status bits 1 to 3 or on the interrupt pointer.
- R9: Reading the command (address 0) returns bits 2:0 as last written, with bits 3 and 4 zero. Status bits 3 and 4 stay set until reset.
- R10: Status (address 1) is read-only. Writes to addresses 1, 4, 5, 6 and 7 change nothing.
- R11: `qh_upd_i` loads `qh_val_i` into the head. A same-cycle disable from R3 takes priority and leaves zero.
- R12: The read map is: 0 command, 1 status, 2 root staging, 3 interrupt staging, 4 queue head, 5 active root, 6 active interrupt table. Address 7 reads zero. All reads are zero-extended and combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write register address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | DATA_W | Read data |
| qh_upd_i | input | 1 | Queue head update strobe from queue engine |
| qh_val_i | input | QH_W | New queue head value |
| sts_o | output | 5 | Global status bits |
| qi_wake_o | output | 1 | One-cycle queue engine wake pulse |
| root_ptr_o | output | PTR_W | Active root table pointer |
| irt_ptr_o | output | PTR_W | Active interrupt table pointer |
| qhead_o | output | QH_W | Invalidation queue head |

## Verification
Two instances, one with every capability and one with none, receive identical stimulus. Each write therefore shows both the honoured and the ignored path of R8.

Directed sequences cover several cases:
- repeated writes of an unchanged enable bit, which separate edge detection from level following (no second wake, no head clear)
- a disable that coincides with an engine head update, which exposes the priority of R11
- trigger writes with freshly staged addresses, which show which staging value is latched

Random writes spread over all eight addresses, mixed with engine updates. After every cycle all outputs and all readable registers are compared against a bench model.

// File: rtl/gcmd_pkg.sv
package gcmd_pkg;
  localparam int unsigned NCMD   = 5;
  localparam int unsigned B_QI   = 0;
  localparam int unsigned B_IR   = 1;
  localparam int unsigned B_CF   = 2;
  localparam int unsigned B_SIRT = 3;
  localparam int unsigned B_SRT  = 4;
  localparam int unsigned NLVL   = B_CF + 1;  // level (persistent) command bits
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_CMD      = 3'd0,
    RA_STS      = 3'd1,
    RA_ROOT_STG = 3'd2,
    RA_IRT_STG  = 3'd3,
    RA_QHEAD    = 3'd4,
    RA_ROOT_ACT = 3'd5,
    RA_IRT_ACT  = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic qi_on;
    logic qi_off;
    logic ir_on;
    logic ir_off;
    logic cf_on;
    logic cf_off;
    logic irt_go;
    logic root_go;
  } cmd_act_t;
endpackage

// File: rtl/gcmd_decode.sv
module gcmd_decode
  import gcmd_pkg::*;
#(
  parameter bit CAP_QI = 1'b1,
  parameter bit CAP_IR = 1'b1
) (
  input  logic            wr_i,
  input  logic [NCMD-1:0] new_i,
  input  logic [NLVL-1:0] old_i,
  output cmd_act_t        act_o
);
  logic [NLVL-1:0] chg;
  assign chg = new_i[NLVL-1:0] ^ old_i;

  always_comb begin
    act_o = '0;
    if (wr_i) begin
      if (CAP_QI && chg[B_QI]) begin
        act_o.qi_on  = new_i[B_QI];
        act_o.qi_off = !new_i[B_QI];
      end
      if (CAP_IR) begin
        if (chg[B_IR]) begin
          act_o.ir_on  = new_i[B_IR];
          act_o.ir_off = !new_i[B_IR];
        end
        if (chg[B_CF]) begin
          act_o.cf_on  = new_i[B_CF];
          act_o.cf_off = !new_i[B_CF];
        end
        act_o.irt_go = new_i[B_SIRT];
      end
      act_o.root_go = new_i[B_SRT];  // not capability gated
    end
  end
endmodule

// File: rtl/gcmd_status.sv
module gcmd_status
  import gcmd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cmd_act_t        act_i,
  output logic [NCMD-1:0] sts_o,
  output logic            wake_o
);
  logic [NLVL-1:0]      on_v, off_v, lvl_q;
  logic [NCMD-NLVL-1:0] go_v, stk_q;

  assign on_v  = {act_i.cf_on,  act_i.ir_on,  act_i.qi_on};
  assign off_v = {act_i.cf_off, act_i.ir_off, act_i.qi_off};
  assign go_v  = {act_i.root_go, act_i.irt_go};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      stk_q  <= '0;
      wake_o <= 1'b0;
    end else begin
      for (int i = 0; i < int'(NLVL); i++) begin
        if (on_v[i])       lvl_q[i] <= 1'b1;
        else if (off_v[i]) lvl_q[i] <= 1'b0;
      end
      stk_q  <= stk_q | go_v;
      wake_o <= act_i.qi_on;
    end
  end

  assign sts_o = {stk_q, lvl_q};
endmodule

// File: rtl/gcmd_ptr.sv
module gcmd_ptr #(
  parameter int unsigned PTR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stg_we_i,
  input  logic [PTR_W-1:0] stg_d_i,
  input  logic             go_i,
  output logic [PTR_W-1:0] stg_o,
  output logic [PTR_W-1:0] act_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_o <= '0;
      act_o <= '0;
    end else begin
      if (stg_we_i) stg_o <= stg_d_i;
      if (go_i)     act_o <= stg_o;
    end
  end
endmodule

// File: rtl/gcmd_handler.sv
module gcmd_handler
  import gcmd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PTR_W  = 32,
  parameter int unsigned QH_W   = 16,
  parameter bit          CAP_QI = 1'b1,
  parameter bit          CAP_IR = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              qh_upd_i,
  input  logic [QH_W-1:0]   qh_val_i,
  output logic [4:0]        sts_o,
  output logic              qi_wake_o,
  output logic [PTR_W-1:0]  root_ptr_o,
  output logic [PTR_W-1:0]  irt_ptr_o,
  output logic [QH_W-1:0]   qhead_o
);
  localparam int unsigned NPTR = 2;

  logic            cmd_we;
  logic [NLVL-1:0] cmd_q;
  cmd_act_t        act;
  logic [NPTR-1:0] stg_we_v, go_v;
  logic [PTR_W-1:0] stg_v [NPTR];
  logic [PTR_W-1:0] act_v [NPTR];

  assign cmd_we = wr_en_i && (wr_addr_i == RA_CMD);

  gcmd_decode #(.CAP_QI(CAP_QI), .CAP_IR(CAP_IR)) u_dec (
    .wr_i  (cmd_we),
    .new_i (wr_data_i[NCMD-1:0]),
    .old_i (cmd_q),
    .act_o (act)
  );

  gcmd_status u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .sts_o  (sts_o),
    .wake_o (qi_wake_o)
  );

  // one-shot trigger bits are not kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_q <= '0;
    else if (cmd_we) cmd_q <= wr_data_i[NLVL-1:0];
  end

  // disable clear wins over engine update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          qhead_o <= '0;
    else if (act.qi_off)  qhead_o <= '0;
    else if (qh_upd_i)    qhead_o <= qh_val_i;
  end

  assign stg_we_v[0] = wr_en_i && (wr_addr_i == RA_ROOT_STG);
  assign stg_we_v[1] = wr_en_i && (wr_addr_i == RA_IRT_STG);
  assign go_v        = {act.irt_go, act.root_go};

  for (genvar g = 0; g < int'(NPTR); g++) begin : g_ptr
    gcmd_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .stg_we_i (stg_we_v[g]),
      .stg_d_i  (wr_data_i[PTR_W-1:0]),
      .go_i     (go_v[g]),
      .stg_o    (stg_v[g]),
      .act_o    (act_v[g])
    );
  end

  assign root_ptr_o = act_v[0];
  assign irt_ptr_o  = act_v[1];

  always_comb begin
    unique case (rd_addr_i)
      RA_CMD:      rd_data_o = DATA_W'(cmd_q);
      RA_STS:      rd_data_o = DATA_W'(sts_o);
      RA_ROOT_STG: rd_data_o = DATA_W'(stg_v[0]);
      RA_IRT_STG:  rd_data_o = DATA_W'(stg_v[1]);
      RA_QHEAD:    rd_data_o = DATA_W'(qhead_o);
      RA_ROOT_ACT: rd_data_o = DATA_W'(act_v[0]);
      RA_IRT_ACT:  rd_data_o = DATA_W'(act_v[1]);
      default:     rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/gcmd_checker.sv
module gcmd_checker
  import gcmd_pkg::*;
#(
  parameter bit          CAP_QI = 1'b1,
  parameter bit          CAP_IR = 1'b1,
  parameter int unsigned PTR_W  = 32,
  parameter int unsigned QH_W   = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_cmd_i,
  input logic [NCMD-1:0]  wdata_i,
  input logic [NLVL-1:0]  cmd_q_i,
  input logic [NCMD-1:0]  sts_i,
  input logic             wake_i,
  input logic [QH_W-1:0]  head_i,
  input logic [PTR_W-1:0] root_stg_i,
  input logic [PTR_W-1:0] irt_stg_i,
  input logic [PTR_W-1:0] root_i,
  input logic [PTR_W-1:0] irt_i
);
  a_r2_qi_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CAP_QI && wr_cmd_i && !cmd_q_i[B_QI] && wdata_i[B_QI]) |=> (sts_i[B_QI] && wake_i));

  a_r2_wake_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |-> $past(wr_cmd_i && wdata_i[B_QI] && !cmd_q_i[B_QI]));

  a_r3_qi_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CAP_QI && wr_cmd_i && cmd_q_i[B_QI] && !wdata_i[B_QI]) |=> (!sts_i[B_QI] && head_i == '0));

  a_r4_ir_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CAP_IR && wr_cmd_i && (wdata_i[B_IR] != cmd_q_i[B_IR])) |=> (sts_i[B_IR] == $past(wdata_i[B_IR])));

  a_r5_cf_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CAP_IR && wr_cmd_i && (wdata_i[B_CF] != cmd_q_i[B_CF])) |=> (sts_i[B_CF] == $past(wdata_i[B_CF])));

  a_r6_irt_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CAP_IR && wr_cmd_i && wdata_i[B_SIRT]) |=> (sts_i[B_SIRT] && irt_i == $past(irt_stg_i)));

  a_r7_root_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd_i && wdata_i[B_SRT]) |=> (sts_i[B_SRT] && root_i == $past(root_stg_i)));

  a_r9_ptr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_i[B_SRT] || sts_i[B_SIRT]) |=> ((sts_i[B_SRT] || !$past(sts_i[B_SRT])) &&
                                          (sts_i[B_SIRT] || !$past(sts_i[B_SIRT]))));

  if (!CAP_IR) begin : g_no_ir
    a_r8_ir_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_i[B_SIRT:B_IR] == '0) && $stable(irt_i));
  end
  if (!CAP_QI) begin : g_no_qi
    a_r8_qi_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sts_i[B_QI] && !wake_i);
  end
endmodule

bind gcmd_handler gcmd_checker #(
  .CAP_QI(CAP_QI), .CAP_IR(CAP_IR), .PTR_W(PTR_W), .QH_W(QH_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_cmd_i   (cmd_we),
  .wdata_i    (wr_data_i[4:0]),
  .cmd_q_i    (cmd_q),
  .sts_i      (sts_o),
  .wake_i     (qi_wake_o),
  .head_i     (qhead_o),
  .root_stg_i (stg_v[0]),
  .irt_stg_i  (stg_v[1]),
  .root_i     (root_ptr_o),
  .irt_i      (irt_ptr_o)
);

// File: tb/sim_gcmd_handler.sv
module sim_gcmd_handler;
  localparam int CLK_PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic        qh_upd = 1'b0;
  logic [15:0] qh_val = '0;

  logic [31:0] rd_d   [2];
  logic [4:0]  sts_d  [2];
  logic        wake_d [2];
  logic [31:0] root_d [2];
  logic [31:0] irt_d  [2];
  logic [15:0] head_d [2];

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gcmd_handler u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_d[0]), .qh_upd_i(qh_upd), .qh_val_i(qh_val),
    .sts_o(sts_d[0]), .qi_wake_o(wake_d[0]), .root_ptr_o(root_d[0]), .irt_ptr_o(irt_d[0]),
    .qhead_o(head_d[0]));

  gcmd_handler #(.CAP_QI(1'b0), .CAP_IR(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_d[1]), .qh_upd_i(qh_upd), .qh_val_i(qh_val),
    .sts_o(sts_d[1]), .qi_wake_o(wake_d[1]), .root_ptr_o(root_d[1]), .irt_ptr_o(irt_d[1]),
    .qhead_o(head_d[1]));

  // bench model, index 0 = all capabilities, 1 = none
  bit          cap_qi [2] = '{1'b1, 1'b0};
  bit          cap_ir [2] = '{1'b1, 1'b0};
  logic [2:0]  m_cmd  [2];
  logic [4:0]  m_sts  [2];
  logic        m_wake [2];
  logic [31:0] m_rstg [2];
  logic [31:0] m_istg [2];
  logic [31:0] m_root [2];
  logic [31:0] m_irt  [2];
  logic [15:0] m_head [2];

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_cmd[k] = '0; m_sts[k] = '0; m_wake[k] = 1'b0; m_rstg[k] = '0;
      m_istg[k] = '0; m_root[k] = '0; m_irt[k] = '0; m_head[k] = '0;
    end
  endtask

  function automatic logic [31:0] exp_rd(int k, logic [2:0] a);
    case (a)
      3'd0: return 32'(m_cmd[k]);
      3'd1: return 32'(m_sts[k]);
      3'd2: return m_rstg[k];
      3'd3: return m_istg[k];
      3'd4: return 32'(m_head[k]);
      3'd5: return m_root[k];
      3'd6: return m_irt[k];
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_step(logic we, logic [2:0] a, logic [31:0] d, logic hw, logic [15:0] hv);
    for (int k = 0; k < 2; k++) begin
      logic [2:0] chg;
      logic clr;
      clr = 1'b0;
      m_wake[k] = 1'b0;
      if (we) begin
        case (a)
          3'd0: begin
            chg = d[2:0] ^ m_cmd[k];
            if (cap_qi[k] && chg[0]) begin
              m_sts[k][0] = d[0];
              if (d[0]) m_wake[k] = 1'b1; else clr = 1'b1;
            end
            if (cap_ir[k]) begin
              if (chg[1]) m_sts[k][1] = d[1];
              if (chg[2]) m_sts[k][2] = d[2];
              if (d[3]) begin m_irt[k] = m_istg[k]; m_sts[k][3] = 1'b1; end
            end
            if (d[4]) begin m_root[k] = m_rstg[k]; m_sts[k][4] = 1'b1; end
            m_cmd[k] = d[2:0];
          end
          3'd2: m_rstg[k] = d;
          3'd3: m_istg[k] = d;
          default: ;
        endcase
      end
      if (clr) m_head[k] = '0;
      else if (hw) m_head[k] = hv;
    end
  endtask

  task automatic chk(string tag, string what, int k, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s u%0d act=%h exp=%h", tag, what, k, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int k = 0; k < 2; k++) begin
      chk(tag, "sts", k, 32'(sts_d[k]), 32'(m_sts[k]));
      chk(tag, "wake", k, 32'(wake_d[k]), 32'(m_wake[k]));
      chk(tag, "root", k, root_d[k], m_root[k]);
      chk(tag, "irt", k, irt_d[k], m_irt[k]);
      chk(tag, "head", k, 32'(head_d[k]), 32'(m_head[k]));
    end
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #1;
      for (int k = 0; k < 2; k++) chk(tag, $sformatf("rd%0d", a), k, rd_d[k], exp_rd(k, 3'(a)));
    end
  endtask

  task automatic step(string tag, logic we, logic [2:0] a, logic [31:0] d,
                      logic hw = 1'b0, logic [15:0] hv = '0);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; qh_upd = hw; qh_val = hv;
    @(posedge clk);
    model_step(we, a, d, hw, hv);
    #1;
    check_all(tag);
    @(negedge clk);
    wr_en = 1'b0; qh_upd = 1'b0;
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 3'd0, 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    @(negedge clk) rst_n = 1'b1;
    idle("R1");

    // R10: status and other read-only addresses ignore writes
    step("R10", 1'b1, 3'd1, 32'hFFFF_FFFF);
    step("R10", 1'b1, 3'd4, 32'h0000_ABCD);
    step("R10", 1'b1, 3'd5, 32'h1111_2222);
    step("R10", 1'b1, 3'd7, 32'h3333_4444);

    // R7: root pointer latched in both instances
    step("R7", 1'b1, 3'd2, 32'hCAFE_0000);
    step("R7", 1'b1, 3'd0, 32'h10);
    // R6 and R8: interrupt pointer only where capable
    step("R6", 1'b1, 3'd3, 32'hBEEF_1000);
    step("R6", 1'b1, 3'd0, 32'h08);
    // R12: staging changes do not move active pointers
    step("R12", 1'b1, 3'd3, 32'h1234_5678);
    step("R12", 1'b1, 3'd2, 32'h8765_4321);

    // R2: enable pulses wake once, rewrite does not
    step("R2", 1'b1, 3'd0, 32'h01);
    idle("R2");
    step("R2", 1'b1, 3'd0, 32'h01);
    // R11: engine moves head
    step("R11", 1'b0, 3'd0, 32'h0, 1'b1, 16'h0055);
    // R3 with R11 priority: disable together with engine update
    step("R3", 1'b1, 3'd0, 32'h00, 1'b1, 16'h0077);
    step("R11", 1'b0, 3'd0, 32'h0, 1'b1, 16'h0033);
    // R3: writing 0 again keeps head
    step("R3", 1'b1, 3'd0, 32'h00);

    // R4 and R5 toggles
    step("R4", 1'b1, 3'd0, 32'h02);
    step("R5", 1'b1, 3'd0, 32'h06);
    step("R5", 1'b1, 3'd0, 32'h02);
    step("R4", 1'b1, 3'd0, 32'h00);
    // R9: trigger bits not stored, pointer status sticky
    step("R9", 1'b1, 3'd0, 32'h1F);
    step("R9", 1'b1, 3'd0, 32'h00);
    idle("R9");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] a;
      logic [31:0] d;
      int r;
      r = int'($urandom_range(0, 9));
      a = (r < 5) ? 3'd0 : 3'($urandom_range(0, 7));
      d = $urandom();
      step("R2/R3/R4/R5/R6/R7", ($urandom_range(0, 3) != 0), a, d,
           ($urandom_range(0, 3) == 0), 16'($urandom()));
    end

    // R1: reset again clears sticky state
    @(negedge clk) rst_n = 1'b0;
    model_reset();
    #1;
    check_all("R1");
    @(negedge clk) rst_n = 1'b1;
    idle("R1");
    finish_run();
  end
endmodule